// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Sequencer

This block moves data for up to sixteen channels over one simple memory master port. Each channel holds a descriptor in registers: a source address, a destination address, a unit count, an address step size, per-address increment controls, a bus-release mode and a reload control. A descriptor is written whole through the configuration port, and the same write also stores it in the channel's shadow copy. Once enabled, a channel waits for a trigger. The trigger can come from its peripheral request line, from its software request bit, or, for one chosen channel, from the external request input. A trigger then runs the channel until its count is spent.

Each unit transfer is a read of one item at the source followed by a write of that item to the destination. Between units the mode decides what happens to the bus. In burst mode the channel keeps it. In cycle-steal mode it gives the bus up for one cycle and arbitration runs again. In the two intermittent modes it gives the bus up for 16 or 64 cycles. Arbitration uses a fixed priority with channel 0 the highest, and it runs only between unit transfers. When the last unit finishes, the channel pulses its completion flag. It then either disables itself or restores its descriptor from the shadow copy and stays enabled.

The control is a four-state machine. IDLE picks the highest-priority ready channel and goes to READ. READ holds a read request and goes to WRITE on acknowledge. WRITE holds a write request. On acknowledge it goes back to READ (burst, more units left), to IDLE (cycle-steal, or the last unit), or to GAP (intermittent, more units left). GAP keeps the bus quiet until its counter expires and then returns to IDLE.

Top module: `dma_seq`

## Requirements
- R1: After reset `mem_req` is low, `done` is all zeros, and no channel is enabled or active.
- R2: Every unit transfer is a read (`mem_we`=0) at the source address, followed in the very next cycle after its acknowledge by a write (`mem_we`=1) at the destination address. `mem_we` is never high without `mem_req`.
- R3: The data written in a unit equals the `mem_rdata` value returned by that unit's read.
- R4: When several channels are ready at an arbitration point, the lowest-numbered channel is served first. A channel released in cycle-steal mode is served again ahead of a lower-priority one that is still ready.
- R5: Mode value 0 (burst): `mem_req` stays high from the first read to the last write, with no low cycle between units.
- R6: Mode value 1 (cycle-steal): `mem_req` is low for exactly one cycle between consecutive units of a channel when no higher-priority channel is ready.
- R7: Mode values 2 and 3 (intermittent): `mem_req` is low for exactly 16 (value 2) or 64 (value 3) cycles between consecutive units.
- R8: After each unit, an address whose increment bit is 1 advances by 1, 2 or 4 for size codes 0, 1 and 2. An address whose increment bit is 0 stays fixed. `mem_size` carries the size code.
- R9: When the count runs out without reload, `done[ch]` is high for exactly one cycle, the cycle after the final write acknowledge, and the channel disables itself. A later trigger then starts no transfer. At most one `done` bit is high at a time.
- R10: With `cfg_reload`=1, finishing the count restores source, destination and count from the shadow copy and keeps the channel enabled. A new trigger repeats the same transfer, and `done` pulses each time.
- R11: A trigger that arrives while its channel is disabled is dropped. Enabling the channel afterwards starts no transfer.
- R12: A channel is triggered by its `periph_req` bit or its `sw_req` bit. Channel `EXT_CH` (default 0) is also triggered by `ext_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Writes the descriptor fields into channel `cfg_ch` |
| cfg_ch | input | CHW | Channel selected by the configuration write |
| cfg_src | input | ADDR_W | Source start address |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_cnt | input | CNT_W | Number of unit transfers (0 means never runs) |
| cfg_mode | input | 2 | 0 burst, 1 cycle-steal, 2 intermittent 16, 3 intermittent 64 |
| cfg_size | input | 2 | Address step code: 0 = 1, 1 = 2, 2 = 4 |
| cfg_src_inc | input | 1 | Source advances after each unit |
| cfg_dst_inc | input | 1 | Destination advances after each unit |
| cfg_reload | input | 1 | Restore the descriptor from the shadow copy at completion |
| cfg_en | input | 1 | Channel enable written with the descriptor |
| periph_req | input | NCH | Peripheral trigger per channel |
| ext_req | input | 1 | External trigger for channel `EXT_CH` |
| sw_req | input | NCH | Software trigger per channel |
| mem_req | output | 1 | Bus request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access address |
| mem_size | output | 2 | Item size code of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| done | output | NCH | One-cycle completion pulse per channel |

## Verification
The hardest case to reach from the ports is the exact length of the bus-release window, because it only shows up as the run of low `mem_req` cycles between two units of one channel. The bench's memory model logs the length of every low run that falls between two request periods. Each mode test then runs one channel alone with a count of two or three, so the logged runs cover only that channel's unit boundaries and can be compared with 0, 1, 16 and 64. Priority needs two channels that become ready in the same cycle from different trigger sources, and the write-address log shows the service order.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 12;
    localparam int GAP_SHORT = 16;
    localparam int GAP_LONG  = 64;
    localparam int GAP_W     = $clog2(GAP_LONG);

    typedef enum logic [1:0] {
        MODE_BURST = 2'd0,
        MODE_STEAL = 2'd1,
        MODE_GAP16 = 2'd2,
        MODE_GAP64 = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        xfer_mode_e        mode;
        logic [1:0]        size;
        logic              src_inc;
        logic              dst_inc;
        logic              reload;
    } desc_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2,
        S_GAP   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cfg_we,
    input  desc_t cfg_desc,
    input  logic  cfg_en,
    input  logic  trig,
    input  logic  step,
    output desc_t cur,
    output logic  ready,
    output logic  done_pulse
);
    desc_t             shadow;
    logic              en_q;
    logic              active_q;
    logic [ADDR_W-1:0] stride;

    assign stride = ADDR_W'(1) << cur.size;
    assign ready  = en_q && active_q && (cur.cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur        <= '0;
            shadow     <= '0;
            en_q       <= 1'b0;
            active_q   <= 1'b0;
            done_pulse <= 1'b0;
        end else if (cfg_we) begin
            cur        <= cfg_desc;
            shadow     <= cfg_desc;
            en_q       <= cfg_en;
            active_q   <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (en_q && trig) begin
                active_q <= 1'b1;
            end
            if (step) begin
                if (cur.cnt == CNT_W'(1)) begin
                    done_pulse <= 1'b1;
                    active_q   <= 1'b0;
                    if (cur.reload) begin
                        cur.src <= shadow.src;
                        cur.dst <= shadow.dst;
                        cur.cnt <= shadow.cnt;
                    end else begin
                        cur.cnt <= '0;
                        en_q    <= 1'b0;
                    end
                end else begin
                    cur.cnt <= cur.cnt - CNT_W'(1);
                    if (cur.src_inc) cur.src <= cur.src + stride;
                    if (cur.dst_inc) cur.dst <= cur.dst + stride;
                end
            end
        end
    end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int EXT_CH = 0,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [CNT_W-1:0]  cfg_cnt,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_src_inc,
    input  logic              cfg_dst_inc,
    input  logic              cfg_reload,
    input  logic              cfg_en,
    input  logic [NCH-1:0]    periph_req,
    input  logic              ext_req,
    input  logic [NCH-1:0]    sw_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [NCH-1:0]    done
);
    seq_state_e        state, nxt;
    logic [CHW-1:0]    cur_ch;
    logic [GAP_W-1:0]  gap_cnt;
    logic [DATA_W-1:0] data_q;

    desc_t             new_desc;
    desc_t             ch_desc [NCH];
    logic [NCH-1:0]    ch_ready;
    logic [NCH-1:0]    ch_step;
    logic              any_rdy;
    logic [CHW-1:0]    win_ch;
    desc_t             sel;

    logic unit_end;
    logic unit_last;
    logic burst_sel;
    logic steal_sel;
    logic in_gap;

    assign new_desc = '{src: cfg_src, dst: cfg_dst, cnt: cfg_cnt,
                        mode: xfer_mode_e'(cfg_mode), size: cfg_size,
                        src_inc: cfg_src_inc, dst_inc: cfg_dst_inc,
                        reload: cfg_reload};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic trig_i;
        if (i == EXT_CH) begin : g_ext
            assign trig_i = periph_req[i] | sw_req[i] | ext_req;
        end else begin : g_int
            assign trig_i = periph_req[i] | sw_req[i];
        end
        assign ch_step[i] = unit_end && (cur_ch == CHW'(i));

        dma_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we && (cfg_ch == CHW'(i))),
            .cfg_desc   (new_desc),
            .cfg_en     (cfg_en),
            .trig       (trig_i),
            .step       (ch_step[i]),
            .cur        (ch_desc[i]),
            .ready      (ch_ready[i]),
            .done_pulse (done[i])
        );
    end

    dma_prio_arb #(.N(NCH)) u_arb (
        .req (ch_ready),
        .any (any_rdy),
        .idx (win_ch)
    );

    assign sel       = ch_desc[cur_ch];
    assign unit_end  = (state == S_WRITE) && mem_ack;
    assign unit_last = (sel.cnt == CNT_W'(1));
    assign burst_sel = (sel.mode == MODE_BURST);
    assign steal_sel = (sel.mode == MODE_STEAL);
    assign in_gap    = (state == S_GAP);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Channel, gap timer and data holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch  <= '0;
            gap_cnt <= '0;
            data_q  <= '0;
        end else begin
            if (state == S_IDLE && any_rdy) begin
                cur_ch <= win_ch;
            end
            if (state == S_READ && mem_ack) begin
                data_q <= mem_rdata;
            end
            if (unit_end) begin
                gap_cnt <= (sel.mode == MODE_GAP64) ? GAP_W'(GAP_LONG - 2)
                                                    : GAP_W'(GAP_SHORT - 2);
            end else if (in_gap && gap_cnt != '0) begin
                gap_cnt <= gap_cnt - GAP_W'(1);
            end
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (any_rdy) nxt = S_READ;
            S_READ:  if (mem_ack) nxt = S_WRITE;
            S_WRITE: begin
                if (mem_ack) begin
                    if (unit_last) begin
                        nxt = S_IDLE;
                    end else begin
                        unique case (sel.mode)
                            MODE_BURST: nxt = S_READ;
                            MODE_STEAL: nxt = S_IDLE;
                            default:    nxt = S_GAP;
                        endcase
                    end
                end
            end
            S_GAP:   if (gap_cnt == '0) nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sel.src;
        mem_size  = sel.size;
        mem_wdata = data_q;
        unique case (state)
            S_READ:  mem_req = 1'b1;
            S_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = sel.dst;
            end
            S_IDLE, S_GAP: mem_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
    parameter int NCH = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_ack,
    input logic [NCH-1:0] done,
    input logic           unit_end,
    input logic           unit_last,
    input logic           burst_sel,
    input logic           steal_sel,
    input logic           in_gap
);
    // R2
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

    // R2
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R5
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_end && burst_sel && !unit_last) |=> (mem_req && !mem_we));

    // R6
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_end && steal_sel) |=> !mem_req);

    // R7
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap |-> !mem_req);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    // R9
    done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_end && unit_last) |=> (done != '0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |=> (done == '0));
endmodule

bind dma_seq dma_seq_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .done      (done),
    .unit_end  (unit_end),
    .unit_last (unit_last),
    .burst_sel (burst_sel),
    .steal_sel (steal_sel),
    .in_gap    (in_gap)
);

// File: tb/sim_dma_seq.sv
module sim_dma_seq;
    import dma_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int CHW = $clog2(NCH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CHW-1:0]    cfg_ch = '0;
    logic [ADDR_W-1:0] cfg_src = '0, cfg_dst = '0;
    logic [CNT_W-1:0]  cfg_cnt = '0;
    logic [1:0]        cfg_mode = '0, cfg_size = '0;
    logic              cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0;
    logic              cfg_reload = 1'b0, cfg_en = 1'b0;
    logic [NCH-1:0]    periph_req = '0, sw_req = '0;
    logic              ext_req = 1'b0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [1:0]        mem_size;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_ack;
    logic [NCH-1:0]    done;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_seq #(.NCH(NCH), .EXT_CH(0)) u0 (.*);

    function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
        return 32'hA500_0000 | DATA_W'(a);
    endfunction

    // Memory model with logs of writes, low-run lengths and completions
    logic              log_clr = 1'b0;
    logic [ADDR_W-1:0] wlog_addr [32];
    logic [DATA_W-1:0] wlog_data [32];
    int                wn;
    int                runs [16];
    int                rn;
    int                low_len;
    logic              seen_hi;
    logic              req_seen;
    logic [NCH-1:0]    done_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack && !mem_we) mem_rdata <= pat(mem_addr);
        end
    end

    always_ff @(posedge clk) begin
        if (log_clr) begin
            wn <= 0; rn <= 0; low_len <= 0; seen_hi <= 1'b0;
            req_seen <= 1'b0; done_seen <= '0;
        end else begin
            done_seen <= done_seen | done;
            if (mem_req) req_seen <= 1'b1;
            if (mem_req && mem_we && mem_ack && wn < 32) begin
                wlog_addr[wn] <= mem_addr;
                wlog_data[wn] <= mem_wdata;
                wn <= wn + 1;
            end
            if (mem_req) begin
                if (seen_hi && low_len != 0 && rn < 16) begin
                    runs[rn] <= low_len;
                    rn <= rn + 1;
                end
                low_len <= 0;
                seen_hi <= 1'b1;
            end else if (seen_hi) begin
                low_len <= low_len + 1;
            end
        end
    end

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic cfg(input int ch, input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d,
                       input int n, input logic [1:0] m, input logic [1:0] sz,
                       input logic si, input logic di, input logic rl, input logic en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_src = s; cfg_dst = d; cfg_cnt = CNT_W'(n);
        cfg_mode = m; cfg_size = sz; cfg_src_inc = si; cfg_dst_inc = di;
        cfg_reload = rl; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sw_pulse(input logic [NCH-1:0] mask);
        @(negedge clk); sw_req = mask;
        @(negedge clk); sw_req = '0;
    endtask

    task automatic wait_done(input int ch);
        int k;
        for (k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (done_seen[ch] && !mem_req) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 mem_req", mem_req == 1'b0, mem_req, 0);
        check("R1 done", done == '0, done, 0);
    endtask

    task automatic t_burst();
        clear_logs();
        cfg(4, 16'h0010, 16'h0080, 4, 2'd0, 2'd0, 1, 1, 0, 1);
        sw_pulse(NCH'(1) << 4);
        wait_done(4);
        check("R12 sw trigger / R9 done", done_seen[4], done_seen, 16'h0010);
        check("R5 burst write count", wn == 4, wn, 4);
        check("R5 burst no release", rn == 0, rn, 0);
        for (int k = 0; k < 4; k++) begin
            check("R2 R8 burst dst", wlog_addr[k] == 16'h0080 + ADDR_W'(k), wlog_addr[k], 16'h0080 + k);
            check("R3 burst data", wlog_data[k] == pat(16'h0010 + ADDR_W'(k)), wlog_data[k], pat(16'h0010 + ADDR_W'(k)));
        end
        clear_logs();
        sw_pulse(NCH'(1) << 4);
        repeat (40) @(negedge clk);
        check("R9 disabled after done", !req_seen, req_seen, 0);
    endtask

    task automatic t_mode(input int ch, input logic [1:0] m, input int n, input int gap, input string tag);
        clear_logs();
        cfg(ch, 16'h0020, 16'h0090, n, m, 2'd0, 1, 1, 0, 1);
        sw_pulse(NCH'(1) << ch);
        wait_done(ch);
        check({tag, " unit count"}, wn == n, wn, n);
        check({tag, " release count"}, rn == n - 1, rn, n - 1);
        for (int k = 0; k < n - 1; k++)
            check({tag, " release length"}, runs[k] == gap, runs[k], gap);
    endtask

    task automatic t_prio();
        clear_logs();
        cfg(3, 16'h0050, 16'h00D0, 2, 2'd1, 2'd0, 1, 1, 0, 1);
        cfg(1, 16'h0058, 16'h00E0, 2, 2'd1, 2'd0, 1, 1, 0, 1);
        @(negedge clk);
        periph_req = NCH'(1) << 3; sw_req = NCH'(1) << 1;
        @(negedge clk);
        periph_req = '0; sw_req = '0;
        wait_done(3);
        check("R4 R12 both served", wn == 4, wn, 4);
        check("R4 first", wlog_addr[0] == 16'h00E0, wlog_addr[0], 16'h00E0);
        check("R4 second", wlog_addr[1] == 16'h00E1, wlog_addr[1], 16'h00E1);
        check("R4 third", wlog_addr[2] == 16'h00D0, wlog_addr[2], 16'h00D0);
        check("R4 fourth", wlog_addr[3] == 16'h00D1, wlog_addr[3], 16'h00D1);
    endtask

    task automatic t_size_fixed();
        clear_logs();
        cfg(8, 16'h0030, 16'h00A0, 3, 2'd0, 2'd2, 0, 1, 0, 1);
        sw_pulse(NCH'(1) << 8);
        wait_done(8);
        check("R8 count", wn == 3, wn, 3);
        for (int k = 0; k < 3; k++) begin
            check("R8 dst step 4", wlog_addr[k] == 16'h00A0 + ADDR_W'(4 * k), wlog_addr[k], 16'h00A0 + 4 * k);
            check("R8 fixed src", wlog_data[k] == pat(16'h0030), wlog_data[k], pat(16'h0030));
        end
    endtask

    task automatic t_ignore();
        clear_logs();
        cfg(9, 16'h0040, 16'h00B8, 2, 2'd0, 2'd0, 1, 1, 0, 0);
        @(negedge clk); periph_req = NCH'(1) << 9;
        @(negedge clk); periph_req = '0;
        repeat (20) @(negedge clk);
        check("R11 disabled trigger", !req_seen, req_seen, 0);
        cfg(9, 16'h0040, 16'h00B8, 2, 2'd0, 2'd0, 1, 1, 0, 1);
        repeat (20) @(negedge clk);
        check("R11 not queued", !req_seen, req_seen, 0);
    endtask

    task automatic t_reload();
        clear_logs();
        cfg(10, 16'h0040, 16'h00B0, 2, 2'd0, 2'd0, 1, 1, 1, 1);
        sw_pulse(NCH'(1) << 10);
        wait_done(10);
        check("R10 first run", wn == 2 && done_seen[10], wn, 2);
        clear_logs();
        sw_pulse(NCH'(1) << 10);
        wait_done(10);
        check("R10 rerun count", wn == 2, wn, 2);
        check("R10 rerun dst restored", wlog_addr[0] == 16'h00B0, wlog_addr[0], 16'h00B0);
        check("R10 rerun data restored", wlog_data[1] == pat(16'h0041), wlog_data[1], pat(16'h0041));
        check("R10 done again", done_seen[10], done_seen, 16'h0400);
    endtask

    task automatic t_ext();
        clear_logs();
        cfg(0, 16'h0060, 16'h00C0, 1, 2'd0, 2'd0, 1, 1, 0, 1);
        @(negedge clk); ext_req = 1'b1;
        @(negedge clk); ext_req = 1'b0;
        wait_done(0);
        check("R12 ext trigger", wn == 1 && wlog_addr[0] == 16'h00C0, wlog_addr[0], 16'h00C0);
        check("R12 ext done", done_seen[0], done_seen, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_burst();
        t_mode(2, 2'd1, 3, 1,  "R6 steal");
        t_mode(6, 2'd2, 3, 16, "R7 gap16");
        t_mode(7, 2'd3, 2, 64, "R7 gap64");
        t_prio();
        t_size_fixed();
        t_ignore();
        t_reload();
        t_ext();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule